// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

The walker drives a block transfer from a list of buffer descriptors in memory. Each descriptor takes four 32-bit words. Once started at a descriptor address, the walker reads those four words through a one-word-at-a-time read port. It then decides whether the engine owns the entry. For an owned entry it hands the buffer address and byte count to a downstream data mover through a request/acknowledge handshake. It then writes the config word back with ownership removed and moves to the next entry.

The next entry is either the explicit link word or the entry directly after the current one. The walk ends on an entry marked last. An entry the engine does not own stops the walk and raises a status flag. Two write-one-to-clear status bits report completion and stoppage, and the completion bit can drive an interrupt through its own enable. A soft reset input returns the walker to idle from any state.

Top module: `dchain_walker`

## Requirements
- R1: A descriptor at byte address P is read as four words in this order: config at P, size at P+4, buffer address at P+8, link at P+12. In the config word, bit 31 is ownership, bit 4 is chained, bit 3 is first, bit 2 is last and bit 1 is no-completion-flag.
- R2: `start` is accepted only while idle with `cfg_enable` high. A start while disabled causes no memory access and no transfer.
- R3: Each owned descriptor produces exactly one transfer request. The address and length stay steady until `xfer_ack`. At most one of the read, write and transfer requests is high in any cycle.
- R4: A size field of zero means 2^SIZE_W bytes (8192 for the default SIZE_W of 13). SIZE_W may only be 13 or 16.
- R5: If ownership (bit 31) is clear, the walker returns to idle without a transfer or a write-back, and it sets `sts_unavail`.
- R6: After `xfer_ack`, the config word is written back to address P with bit 31 cleared and all other bits unchanged.
- R7: After a descriptor's write-back, `sts_rx_done` is set if the walk is a receive (`cfg_rx_dir` sampled at start) and the descriptor has bit 2 set or bit 1 clear. A transmit walk never sets it.
- R8: `irq` is high exactly while `sts_rx_done` is set and `cfg_irq_en` is high. The enable acts live. `sts_unavail` does not drive `irq`.
- R9: Writing 1 on `sts_clr` bit 0 clears `sts_rx_done`, and writing 1 on bit 1 clears `sts_unavail`. A set in the same cycle wins.
- R10: After the write-back, the walk ends if bit 2 is set, even when bit 4 is also set. Otherwise it continues at the link word if bit 4 is set, or else at P+16.
- R11: The two low bits of the buffer address and of the length are presented as zero. Size bits at and above SIZE_W are ignored.
- R12: `cfg_soft_rst` returns the walker to idle on the next clock, drops every request, clears both status bits and performs no write-back.
- R13: `cfg_fixed_burst` is sampled at start and held on `xfer_fixed` for the whole walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_soft_rst | input | 1 | Synchronous engine clear |
| cfg_enable | input | 1 | Permits a start |
| cfg_fixed_burst | input | 1 | Fixed-burst option, sampled at start |
| cfg_rx_dir | input | 1 | 1 = receive walk, sampled at start |
| cfg_irq_en | input | 1 | Enable of the completion interrupt |
| start | input | 1 | Begin a walk at start_addr |
| start_addr | input | 32 | Address of the first descriptor |
| busy | output | 1 | Walk in progress |
| mrd_req | output | 1 | Descriptor word read request |
| mrd_addr | output | 32 | Read address |
| mrd_rvalid | input | 1 | Read data valid |
| mrd_rdata | input | 32 | Read data |
| mwr_req | output | 1 | Write-back request |
| mwr_addr | output | 32 | Write-back address |
| mwr_data | output | 32 | Write-back data |
| mwr_ack | input | 1 | Write-back accepted |
| xfer_req | output | 1 | Buffer transfer request |
| xfer_addr | output | 32 | Buffer address |
| xfer_len | output | SIZE_W+1 | Buffer length in bytes |
| xfer_fixed | output | 1 | Fixed-burst flag for the mover |
| xfer_ack | input | 1 | Transfer accepted |
| sts_rx_done | output | 1 | Receive completion status |
| sts_unavail | output | 1 | Unowned-descriptor status |
| sts_clr | input | 2 | Write-one-to-clear strobes for the status bits |
| irq | output | 1 | Completion interrupt |

## Verification
A corrupted descriptor pointer or word counter shows up at the very next transfer request. The scoreboard then sees a wrong buffer address or length, or a request that was never expected. A wrong follow decision can make the walker step onto an unowned entry, which raises `sts_unavail` within about ten cycles. Lost ownership or flag state shows in the written-back config words and in the status bits, and both are checked right after each walk goes idle. A bad state after soft reset shows on the next cycle as a live request or a non-zero status.

// File: rtl/dchain_pkg.sv
package dchain_pkg;
   localparam int WORD_W     = 32;
   localparam int DESC_WORDS = 4;
   localparam int DESC_BYTES = DESC_WORDS * (WORD_W / 8);

   // config word flag positions (decoded by the walker and by software)
   localparam int OWN_BIT   = 31;
   localparam int CHAIN_BIT = 4;
   localparam int FIRST_BIT = 3;
   localparam int LAST_BIT  = 2;
   localparam int NOCMP_BIT = 1;

   // status vector positions
   localparam int STS_RX_DONE = 0;
   localparam int STS_UNAVAIL = 1;
   localparam int STS_NUM     = 2;

   typedef enum logic [1:0] {
      WALK_IDLE,
      WALK_FETCH,
      WALK_XFER,
      WALK_WBACK
   } walk_state_t;

   typedef struct packed {
      logic own;
      logic chain;
      logic first;
      logic last;
      logic nocmp;
   } desc_flags_t;

   function automatic desc_flags_t flags_of(input logic [WORD_W-1:0] cfg);
      desc_flags_t f;
      f.own   = cfg[OWN_BIT];
      f.chain = cfg[CHAIN_BIT];
      f.first = cfg[FIRST_BIT];
      f.last  = cfg[LAST_BIT];
      f.nocmp = cfg[NOCMP_BIT];
      return f;
   endfunction
endpackage

// File: rtl/dchain_fetch.sv
module dchain_fetch #(
   parameter int WORDS  = 4,
   parameter int WORD_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    soft_rst,
   input  logic                    go,
   input  logic [WORD_W-1:0]       base,
   output logic                    mrd_req,
   output logic [WORD_W-1:0]       mrd_addr,
   input  logic                    mrd_rvalid,
   input  logic [WORD_W-1:0]       mrd_rdata,
   output logic                    done,
   output logic [WORDS*WORD_W-1:0] words
);
   localparam int CNT_W   = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int BYTE_SH = $clog2(WORD_W / 8);

   generate
      if (WORDS < 2 || (WORD_W % 8) != 0) begin : g_bad_cfg
         $error("dchain_fetch: WORDS must be >= 2 and WORD_W a byte multiple");
      end
   endgenerate

   logic             active;
   logic [CNT_W-1:0] cnt;
   logic             take;
   logic             take_last;

   assign take      = active && mrd_rvalid;
   assign take_last = take && (cnt == CNT_W'(WORDS - 1));
   assign mrd_req   = active;
   assign mrd_addr  = base + (WORD_W'(cnt) << BYTE_SH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         done   <= 1'b0;
      end else if (soft_rst) begin
         active <= 1'b0;
         cnt    <= '0;
         done   <= 1'b0;
      end else begin
         done <= take_last;
         if (go) begin
            active <= 1'b1;
            cnt    <= '0;
         end else if (take) begin
            cnt <= cnt + 1'b1;
            if (take_last) active <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         words <= '0;
      end else if (take) begin
         for (int i = 0; i < WORDS; i++) begin
            if (cnt == CNT_W'(i)) words[i*WORD_W +: WORD_W] <= mrd_rdata;
         end
      end
   end
endmodule

// File: rtl/dchain_len.sv
module dchain_len #(
   parameter int SIZE_W = 13,
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] size_word,
   input  logic [WORD_W-1:0] buf_word,
   output logic [WORD_W-1:0] buf_addr,
   output logic [SIZE_W:0]   len
);
   logic unused_size_hi;
   assign unused_size_hi = ^size_word[WORD_W-1:SIZE_W];

   // byte alignment of the buffer start
   assign buf_addr = buf_word & ~WORD_W'(3);

   generate
      if (SIZE_W == 13 || SIZE_W == 16) begin : g_size_ok
         logic [SIZE_W-1:0] field;
         assign field = size_word[SIZE_W-1:0];
         // zero encodes the largest buffer
         assign len = (field == '0) ? {1'b1, {SIZE_W{1'b0}}}
                                    : ({1'b0, field} & ~(SIZE_W + 1)'(3));
      end else begin : g_size_bad
         $error("dchain_len: SIZE_W must be 13 or 16");
         assign len = '0;
      end
   endgenerate
endmodule

// File: rtl/dchain_status.sv
module dchain_status #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_rst,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] irq_en,
   output logic [N-1:0] sts,
   output logic         irq
);
   generate
      if (N < 1) begin : g_bad_n
         $error("dchain_status: N must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sts <= '0;
      else if (soft_rst) sts <= '0;
      else               sts <= (sts & ~clr) | set;
   end

   assign irq = |(sts & irq_en);
endmodule

// File: rtl/dchain_walker.sv
module dchain_walker
   import dchain_pkg::*;
#(
   parameter int SIZE_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_soft_rst,
   input  logic              cfg_enable,
   input  logic              cfg_fixed_burst,
   input  logic              cfg_rx_dir,
   input  logic              cfg_irq_en,
   input  logic              start,
   input  logic [WORD_W-1:0] start_addr,
   output logic              busy,
   output logic              mrd_req,
   output logic [WORD_W-1:0] mrd_addr,
   input  logic              mrd_rvalid,
   input  logic [WORD_W-1:0] mrd_rdata,
   output logic              mwr_req,
   output logic [WORD_W-1:0] mwr_addr,
   output logic [WORD_W-1:0] mwr_data,
   input  logic              mwr_ack,
   output logic              xfer_req,
   output logic [WORD_W-1:0] xfer_addr,
   output logic [SIZE_W:0]   xfer_len,
   output logic              xfer_fixed,
   input  logic              xfer_ack,
   output logic              sts_rx_done,
   output logic              sts_unavail,
   input  logic [1:0]        sts_clr,
   output logic              irq
);
   localparam int LEN_W = SIZE_W + 1;

   generate
      if (SIZE_W >= WORD_W - 2) begin : g_bad_size
         $error("dchain_walker: SIZE_W too wide for the size word");
      end
   endgenerate

   walk_state_t                  state;
   logic [WORD_W-1:0]            ptr;
   logic                         fixed_q;
   logic                         rx_q;
   logic                         fetch_go;
   logic                         fetch_done;
   logic [DESC_WORDS*WORD_W-1:0] words;
   logic [WORD_W-1:0]            w_cfg, w_size, w_buf, w_link;
   desc_flags_t                  flg;
   logic                         accept;
   logic                         wb_fin;
   logic                         more;
   logic [STS_NUM-1:0]           sts_set, sts_vec;
   logic [LEN_W-1:0]             len_d;
   logic                         unused_first;

   assign w_cfg  = words[0*WORD_W +: WORD_W];
   assign w_size = words[1*WORD_W +: WORD_W];
   assign w_buf  = words[2*WORD_W +: WORD_W];
   assign w_link = words[3*WORD_W +: WORD_W];
   assign flg    = flags_of(w_cfg);
   assign unused_first = flg.first;

   assign accept   = (state == WALK_IDLE) && start && cfg_enable;
   assign wb_fin   = (state == WALK_WBACK) && mwr_ack;
   assign more     = !flg.last;
   assign fetch_go = accept || (wb_fin && more);

   dchain_fetch #(
      .WORDS (DESC_WORDS),
      .WORD_W(WORD_W)
   ) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (cfg_soft_rst),
      .go        (fetch_go),
      .base      (ptr),
      .mrd_req   (mrd_req),
      .mrd_addr  (mrd_addr),
      .mrd_rvalid(mrd_rvalid),
      .mrd_rdata (mrd_rdata),
      .done      (fetch_done),
      .words     (words)
   );

   dchain_len #(
      .SIZE_W(SIZE_W),
      .WORD_W(WORD_W)
   ) u_len (
      .size_word(w_size),
      .buf_word (w_buf),
      .buf_addr (xfer_addr),
      .len      (len_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= WALK_IDLE;
         ptr     <= '0;
         fixed_q <= 1'b0;
         rx_q    <= 1'b0;
      end else if (cfg_soft_rst) begin
         state   <= WALK_IDLE;
         ptr     <= '0;
         fixed_q <= 1'b0;
         rx_q    <= 1'b0;
      end else begin
         unique case (state)
            WALK_IDLE: if (accept) begin
               state   <= WALK_FETCH;
               ptr     <= start_addr;
               fixed_q <= cfg_fixed_burst;
               rx_q    <= cfg_rx_dir;
            end
            WALK_FETCH: if (fetch_done) begin
               state <= flg.own ? WALK_XFER : WALK_IDLE;
            end
            WALK_XFER: if (xfer_ack) state <= WALK_WBACK;
            WALK_WBACK: if (mwr_ack) begin
               if (more) begin
                  state <= WALK_FETCH;
                  ptr   <= flg.chain ? w_link : ptr + WORD_W'(DESC_BYTES);
               end else begin
                  state <= WALK_IDLE;
               end
            end
            default: state <= WALK_IDLE;
         endcase
      end
   end

   assign sts_set[STS_RX_DONE] = wb_fin && rx_q && (flg.last || !flg.nocmp);
   assign sts_set[STS_UNAVAIL] = (state == WALK_FETCH) && fetch_done && !flg.own;

   dchain_status #(
      .N(STS_NUM)
   ) u_sts (
      .clk     (clk),
      .rst_n   (rst_n),
      .soft_rst(cfg_soft_rst),
      .set     (sts_set),
      .clr     (sts_clr),
      .irq_en  ({1'b0, cfg_irq_en}),
      .sts     (sts_vec),
      .irq     (irq)
   );

   assign sts_rx_done = sts_vec[STS_RX_DONE];
   assign sts_unavail = sts_vec[STS_UNAVAIL];
   assign busy        = (state != WALK_IDLE);
   assign xfer_req    = (state == WALK_XFER);
   assign xfer_len    = len_d;
   assign xfer_fixed  = fixed_q;
   assign mwr_req     = (state == WALK_WBACK);
   assign mwr_addr    = ptr;
   assign mwr_data    = w_cfg & ~(WORD_W'(1) << OWN_BIT);
endmodule

// File: rtl/dchain_walker_chk.sv
module dchain_walker_chk #(
   parameter int SIZE_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_soft_rst,
   input logic              busy,
   input logic              mrd_req,
   input logic              mwr_req,
   input logic [31:0]       mwr_data,
   input logic              xfer_req,
   input logic              xfer_ack,
   input logic [31:0]       xfer_addr,
   input logic [SIZE_W:0]   xfer_len,
   input logic              sts_rx_done,
   input logic              sts_unavail
);
   assert_xfer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_ack && !cfg_soft_rst) |=>
         (xfer_req && $stable(xfer_addr) && $stable(xfer_len)));

   assert_one_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mrd_req, mwr_req, xfer_req}));

   assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> (xfer_len != '0 && xfer_len <= {1'b1, {SIZE_W{1'b0}}}));

   assert_unavail_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_unavail) |-> (!busy && !xfer_req && !mwr_req));

   assert_wb_own_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mwr_req |-> !mwr_data[31]);

   assert_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> (xfer_addr[1:0] == 2'b00 && xfer_len[1:0] == 2'b00));

   assert_soft_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_soft_rst |=> (!busy && !xfer_req && !mrd_req && !mwr_req
                        && !sts_rx_done && !sts_unavail));
endmodule

bind dchain_walker dchain_walker_chk #(
   .SIZE_W(SIZE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_soft_rst(cfg_soft_rst),
   .busy        (busy),
   .mrd_req     (mrd_req),
   .mwr_req     (mwr_req),
   .mwr_data    (mwr_data),
   .xfer_req    (xfer_req),
   .xfer_ack    (xfer_ack),
   .xfer_addr   (xfer_addr),
   .xfer_len    (xfer_len),
   .sts_rx_done (sts_rx_done),
   .sts_unavail (sts_unavail)
);

// File: tb/tb_dchain_walker.sv
`timescale 1ns/1ps
module tb_dchain_walker;
   localparam int SIZE_W = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_soft_rst = 0, cfg_enable = 0, cfg_fixed_burst = 0, cfg_rx_dir = 0, cfg_irq_en = 0;
   logic start = 0;
   logic [31:0] start_addr = '0;
   logic busy, mrd_req, mwr_req, xfer_req, xfer_fixed, sts_rx_done, sts_unavail, irq;
   logic [31:0] mrd_addr, mwr_addr, mwr_data, xfer_addr;
   logic [SIZE_W:0] xfer_len;
   logic mrd_rvalid = 0, mwr_ack = 0, xfer_ack = 0;
   logic [31:0] mrd_rdata = '0;
   logic [1:0] sts_clr = '0;

   logic [31:0] mem [0:255];

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   typedef struct {
      logic [31:0]     a;
      logic [SIZE_W:0] l;
      logic            f;
      string           tag;
   } exp_t;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   dchain_walker #(.SIZE_W(SIZE_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_soft_rst(cfg_soft_rst), .cfg_enable(cfg_enable),
      .cfg_fixed_burst(cfg_fixed_burst), .cfg_rx_dir(cfg_rx_dir), .cfg_irq_en(cfg_irq_en),
      .start(start), .start_addr(start_addr), .busy(busy),
      .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata),
      .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_data(mwr_data), .mwr_ack(mwr_ack),
      .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_fixed(xfer_fixed),
      .xfer_ack(xfer_ack), .sts_rx_done(sts_rx_done), .sts_unavail(sts_unavail),
      .sts_clr(sts_clr), .irq(irq)
   );

   // memory and mover models: one-cycle registered responses
   always @(posedge clk) begin
      mrd_rvalid <= mrd_req && !mrd_rvalid;
      mrd_rdata  <= mem[mrd_addr[9:2]];
      mwr_ack    <= mwr_req && !mwr_ack;
      if (mwr_req && mwr_ack) mem[mwr_addr[9:2]] <= mwr_data;
      xfer_ack   <= xfer_req && !xfer_ack;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic expect_xfer(input logic [31:0] a, input logic [SIZE_W:0] l,
                              input logic f, input string tag);
      exp_t e;
      e.a = a; e.l = l; e.f = f; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor: compare each accepted transfer with the next expected item
   always @(negedge clk) begin
      if (rst_n && xfer_req && xfer_ack) begin
         if (sb.size() == 0) begin
            chk("R3 unexpected transfer", {32'h0, xfer_addr}, 64'hFFFF_FFFF);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk({e.tag, " addr"}, xfer_addr, e.a);
            chk({e.tag, " len"}, xfer_len, e.l);
            chk("R13 fixed burst", xfer_fixed, e.f);
         end
      end
   end

   task automatic put_desc(input int base, input logic [31:0] cfg, sz, bufa, link);
      mem[base/4]     = cfg;
      mem[base/4 + 1] = sz;
      mem[base/4 + 2] = bufa;
      mem[base/4 + 3] = link;
   endtask

   task automatic kick(input logic [31:0] addr);
      @(negedge clk);
      start_addr = addr;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_clr(input logic [1:0] v);
      @(negedge clk);
      sts_clr = v;
      @(negedge clk);
      sts_clr = '0;
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual hung expected idle");
      report();
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 reset busy", busy, 0);
      chk("R3 reset xfer_req", {xfer_req, mrd_req, mwr_req}, 0);
      chk("R9 reset status", {sts_rx_done, sts_unavail}, 0);
      chk("R8 reset irq", irq, 0);

      // R1/R10: three linked entries, receive, fixed burst
      put_desc(32'h000, 32'h8000_001A, 32'h200, 32'h0001_0000, 32'h040);
      put_desc(32'h040, 32'h8000_0012, 32'h0,   32'h0002_0000, 32'h080);
      put_desc(32'h080, 32'h8000_0004, 32'h40,  32'h0003_0000, 32'hFFC);
      cfg_enable = 1; cfg_rx_dir = 1; cfg_fixed_burst = 1; cfg_irq_en = 1;
      expect_xfer(32'h0001_0000, 14'h200,  1, "R1 first entry");
      expect_xfer(32'h0002_0000, 14'h2000, 1, "R4 zero size");
      expect_xfer(32'h0003_0000, 14'h40,   1, "R10 linked entry");
      kick(32'h000);
      wait_idle();
      chk("R3 all transfers seen", sb.size(), 0);
      chk("R6 writeback 0", mem[0], 32'h0000_001A);
      chk("R6 writeback 1", mem[16], 32'h0000_0012);
      chk("R6 writeback 2", mem[32], 32'h0000_0004);
      chk("R7 rx done after last", sts_rx_done, 1);
      chk("R8 irq enabled", irq, 1);
      chk("R5 no unavail", sts_unavail, 0);

      // R9 write one to clear
      pulse_clr(2'b01);
      chk("R9 rx done cleared", sts_rx_done, 0);
      chk("R8 irq follows", irq, 0);

      // R10/R11 contiguous step, alignment, last wins over chained, transmit
      put_desc(32'h100, 32'h8000_0002, 32'h0000_E107, 32'h0000_4003, 32'h200);
      put_desc(32'h110, 32'h8000_0014, 32'h10,        32'h0000_5000, 32'h200);
      put_desc(32'h200, 32'h0000_0004, 32'h10,        32'h0000_6000, 32'h0);
      cfg_rx_dir = 0; cfg_fixed_burst = 0;
      expect_xfer(32'h0000_4000, 14'h104, 0, "R11 aligned");
      expect_xfer(32'h0000_5000, 14'h10,  0, "R10 contiguous");
      kick(32'h100);
      wait_idle();
      chk("R3 all transfers seen", sb.size(), 0);
      chk("R10 last wins, no unavail", sts_unavail, 0);
      chk("R7 transmit no rx done", sts_rx_done, 0);
      chk("R6 writeback tx 0", mem[64], 32'h0000_0002);
      chk("R6 writeback tx 1", mem[68], 32'h0000_0014);

      // R5 unowned entry
      cfg_rx_dir = 1;
      kick(32'h200);
      wait_idle();
      chk("R5 unavail set", sts_unavail, 1);
      chk("R5 no writeback", mem[128], 32'h0000_0004);
      chk("R8 unavail not on irq", irq, 0);
      chk("R7 no rx done on halt", sts_rx_done, 0);
      pulse_clr(2'b10);
      chk("R9 unavail cleared", sts_unavail, 0);

      // R2 start ignored while disabled
      put_desc(32'h300, 32'h8000_0004, 32'h20, 32'h0000_7000, 32'h0);
      cfg_enable = 0;
      kick(32'h300);
      repeat (20) @(negedge clk);
      chk("R2 stays idle", busy, 0);
      chk("R2 entry untouched", mem[192], 32'h8000_0004);

      // R8 mask, live enable
      cfg_enable = 1; cfg_irq_en = 0;
      expect_xfer(32'h0000_7000, 14'h20, 0, "R3 single entry");
      kick(32'h300);
      wait_idle();
      chk("R7 rx done single", sts_rx_done, 1);
      chk("R8 irq masked", irq, 0);
      @(negedge clk);
      cfg_irq_en = 1;
      #1;
      chk("R8 irq unmasked", irq, 1);

      // R12 soft reset mid walk
      mem[192] = 32'h8000_0004;
      kick(32'h300);
      repeat (2) @(negedge clk);
      cfg_soft_rst = 1;
      @(negedge clk);
      cfg_soft_rst = 0;
      chk("R12 idle after soft reset", busy, 0);
      chk("R12 status cleared", {sts_rx_done, sts_unavail}, 0);
      repeat (30) @(negedge clk);
      chk("R12 no writeback", mem[192], 32'h8000_0004);
      cfg_fixed_burst = 1;
      expect_xfer(32'h0000_7000, 14'h20, 1, "R12 restart");
      kick(32'h300);
      wait_idle();
      chk("R3 all transfers seen", sb.size(), 0);
      chk("R6 writeback after restart", mem[192], 32'h0000_0004);

      repeat (5) @(negedge clk);
      report();
   end
endmodule